// File: doc/BRIEF.md
# Buffered Prescaled Reload Timer

This block is a 16-bit up-counting time base. A programmable divider turns the clock into counter ticks. The counter climbs from zero to a reload limit and wraps back to zero, and that wrap is an overflow. An overflow, or an update forced by software, becomes an update event unless updates are blocked. At an update event the buffered divide ratio and the buffered reload limit become active. The update event also sets a status flag that drives an interrupt request and a DMA request pulse.

Software reaches the block through a single-cycle register port. Writes are captured on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The word addresses are: 0 control, 1 request enables, 2 status, 3 event, 4 count, 5 divide value, 6 reload value. A one-shot option stops counting at the first update. A selectable trigger output can carry the forced-update pulse, the internal count-enable level or the update pulse. The status flag can also be mirrored into bit 31 of the count read-back.

Top module: `tbase_timer`

## Requirements
- R1: After reset, the reload register (addr 6) reads 0xFFFF. Every other register reads 0, and `upd_irq`, `upd_dma` and `trig_out` are 0.
- R2: On each counter tick the count (addr 4, bits 15:0) rises by one. At the active reload limit the next tick returns it to 0, and that wrap is an overflow that sets the status flag (addr 2, bit 0). While the active limit is 0 the count does not move.
- R3: The divide value N (addr 5) makes a tick every N+1 enabled cycles. A written N becomes active only at an update event.
- R4: With control bit 4 at 0, a written reload value (addr 6) is the limit at once. With control bit 4 at 1, the value is held and becomes the limit only at the next update event.
- R5: Writing 1 to bit 0 of addr 3 forces an update, clears the count and the divider phase, and loads the buffered divide value. Addr 3 always reads 0.
- R6: With control bit 1 set, overflows and forced updates make no update event: no flag and no ratio or limit load. A forced update still restarts the count and the divider.
- R7: With control bit 2 set, a forced update does not set the status flag, while an overflow still does.
- R8: Writing 0 to status bit 0 clears the flag and writing 1 leaves it. `upd_irq` equals the flag AND enable bit 0 of addr 1, and a flag set wins over a clear in the same cycle.
- R9: With enable bit 1 of addr 1 set, `upd_dma` pulses for one cycle, in the cycle the flag is set by an update event.
- R10: With control bit 3 set, an update event clears the run bit (control bit 0), and counting stops at once.
- R11: The internal count enable follows the run bit one cycle late.
- R12: With control bit 5 set, bit 31 of the count read-back equals the status flag in the same cycle. Otherwise bit 31 reads 0.
- R13: Control bits 8:6 select `trig_out`: 0 gives the forced-update pulse, 1 gives the count-enable level, 2 gives the update pulse, and any other value gives 0.
- R14: A write to addr 4 loads the count in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, captured at the clock edge |
| bus_addr | input | 3 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| upd_irq | output | 1 | Interrupt request: flag AND enable |
| upd_dma | output | 1 | One-cycle DMA request pulse |
| trig_out | output | 1 | Selected trigger output |

## Verification
Counting is tried with a divide value of 0, where the count steps each cycle. It is also tried with divide values of 1 and 2, where a ratio switched in by a forced update shows up as a changed step spacing. The reload limit is tried with immediate and buffered loading, where the wrap position tells whether the old or the new limit was active. A limit of zero, and a count written above the stopped counter, show blocking and then resumed wrapping. Forced updates are applied with updates blocked and with the flag filter on, and the flag, the count and the step spacing afterwards tell the restart apart from the register load.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    localparam int DATA_W = 32;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_IEN    = 3'd1;
    localparam logic [2:0] A_STAT   = 3'd2;
    localparam logic [2:0] A_EVT    = 3'd3;
    localparam logic [2:0] A_COUNT  = 3'd4;
    localparam logic [2:0] A_PRESC  = 3'd5;
    localparam logic [2:0] A_RELOAD = 3'd6;

    typedef enum logic [2:0] {
        TRG_FORCE  = 3'd0,
        TRG_ENABLE = 3'd1,
        TRG_UPDATE = 3'd2
    } trig_sel_e;

    // Control word layout, LSB at the bottom of the list.
    typedef struct packed {
        logic [2:0] tsel;      // 8:6
        logic       mirror;    // 5
        logic       buf_rld;   // 4
        logic       one_shot;  // 3
        logic       force_qual;// 2 forced update does not flag
        logic       upd_block; // 1
        logic       run;       // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             restart,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] phase;
        logic [CNT_W-1:0] ratio;
    } psc_state_t;

    psc_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (restart) begin
            s_d.phase = '0;
        end else if (cnt_en) begin
            if (s_q.phase == s_q.ratio) begin
                s_d.phase = '0;
                tick      = 1'b1;
            end else begin
                s_d.phase = s_q.phase + 1'b1;
            end
        end
        if (load) begin
            s_d.ratio = preset;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    ratio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> s_q.ratio == $past(s_q.ratio));

    // R5
    psc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> s_q.phase == '0);

endmodule

// File: rtl/tbt_counter.sv
module tbt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    logic [CNT_W-1:0] count_d, count_q;
    logic             live;

    always_comb begin
        count_d = count_q;
        live    = tick && (limit != '0) && !restart && !wr_en;
        ovf     = live && (count_q == limit);
        if (restart) begin
            count_d = '0;
        end else if (wr_en) begin
            count_d = wr_val;
        end else if (live) begin
            count_d = ovf ? '0 : count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> count_q == '0);

    // R2
    zero_limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0 && !restart && !wr_en) |=> count_q == $past(count_q));

    // R5
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> count_q == '0);

    // R14
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restart) |=> count_q == $past(wr_val));

endmodule

// File: rtl/tbt_regs.sv
module tbt_regs
    import tbt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cur_count,
    input  logic              ovf,
    output logic              cnt_en,
    output logic              force_upd,
    output logic              uev,
    output logic [CNT_W-1:0]  presc_pre,
    output logic [CNT_W-1:0]  limit,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic              upd_irq,
    output logic              upd_dma,
    output logic              trig_out
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             irq_en;
        logic             dma_en;
        logic             flag;
        logic [CNT_W-1:0] presc_pre;
        logic [CNT_W-1:0] reload_pre;
        logic [CNT_W-1:0] reload_shd;
        logic             cnt_en;
        logic             force_p;
        logic             uev_p;
        logic             dma_p;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic       flag_set;
    logic       stop_now;
    logic       unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    always_comb begin
        s_d       = s_q;
        force_upd = bus_wr && (bus_addr == A_EVT) && bus_wdata[0];
        uev       = (ovf || force_upd) && !s_q.ctrl.upd_block;
        flag_set  = uev && !(force_upd && s_q.ctrl.force_qual);
        stop_now  = uev && s_q.ctrl.one_shot;

        if (bus_wr) begin
            case (bus_addr)
                A_CTRL:   s_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                A_IEN: begin
                    s_d.irq_en = bus_wdata[0];
                    s_d.dma_en = bus_wdata[1];
                end
                A_STAT:   s_d.flag       = s_q.flag & bus_wdata[0];
                A_PRESC:  s_d.presc_pre  = bus_wdata[CNT_W-1:0];
                A_RELOAD: s_d.reload_pre = bus_wdata[CNT_W-1:0];
                default:  ;
            endcase
        end

        if (uev)      s_d.reload_shd = s_q.reload_pre;
        if (stop_now) s_d.ctrl.run   = 1'b0;
        if (flag_set) s_d.flag       = 1'b1;

        s_d.cnt_en  = s_q.ctrl.run && !stop_now;
        s_d.force_p = force_upd;
        s_d.uev_p   = uev;
        s_d.dma_p   = flag_set && s_q.dma_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.reload_pre <= '1;
            s_q.reload_shd <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_en    = s_q.cnt_en;
    assign presc_pre = s_q.presc_pre;
    assign limit     = s_q.ctrl.buf_rld ? s_q.reload_shd : s_q.reload_pre;
    assign cnt_wr    = bus_wr && (bus_addr == A_COUNT);
    assign cnt_wdata = bus_wdata[CNT_W-1:0];
    assign upd_irq   = s_q.flag && s_q.irq_en;
    assign upd_dma   = s_q.dma_p;

    always_comb begin
        case (trig_sel_e'(s_q.ctrl.tsel))
            TRG_FORCE:  trig_out = s_q.force_p;
            TRG_ENABLE: trig_out = s_q.cnt_en;
            TRG_UPDATE: trig_out = s_q.uev_p;
            default:    trig_out = 1'b0;
        endcase
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata[CTRL_W-1:0] = s_q.ctrl;
            A_IEN:    bus_rdata[1:0]        = {s_q.dma_en, s_q.irq_en};
            A_STAT:   bus_rdata[0]          = s_q.flag;
            A_COUNT: begin
                bus_rdata[CNT_W-1:0] = cur_count;
                bus_rdata[DATA_W-1]  = s_q.ctrl.mirror && s_q.flag;
            end
            A_PRESC:  bus_rdata[CNT_W-1:0]  = s_q.presc_pre;
            A_RELOAD: bus_rdata[CNT_W-1:0]  = s_q.reload_pre;
            default:  bus_rdata = '0;
        endcase
    end

    // R6
    blocked_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ctrl.upd_block |=> s_q.reload_shd == $past(s_q.reload_shd));

    // R7
    qual_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_upd && s_q.ctrl.force_qual && !s_q.flag) |=> !s_q.flag);

    // R9
    dma_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_dma |-> s_q.flag);

    // R10
    one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uev && s_q.ctrl.one_shot) |=> (!s_q.ctrl.run && !s_q.cnt_en));

    // R11
    enable_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.run && !uev) |=> s_q.cnt_en);

    // R8
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !s_q.ctrl.upd_block) |=> s_q.flag);

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              upd_irq,
    output logic              upd_dma,
    output logic              trig_out
);

    logic             cnt_en;
    logic             force_upd;
    logic             uev;
    logic [CNT_W-1:0] presc_pre;
    logic [CNT_W-1:0] limit;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wdata;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             ovf;

    tbt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cur_count (count),
        .ovf       (ovf),
        .cnt_en    (cnt_en),
        .force_upd (force_upd),
        .uev       (uev),
        .presc_pre (presc_pre),
        .limit     (limit),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .upd_irq   (upd_irq),
        .upd_dma   (upd_dma),
        .trig_out  (trig_out)
    );

    tbt_prescaler #(.CNT_W(CNT_W)) psc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .restart (force_upd),
        .load    (uev),
        .preset  (presc_pre),
        .tick    (tick)
    );

    tbt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (force_upd),
        .wr_en   (cnt_wr),
        .wr_val  (cnt_wdata),
        .limit   (limit),
        .count   (count),
        .ovf     (ovf)
    );

endmodule

// File: tb/tbase_timer_tb_top.sv
`timescale 1ns/1ps
module tbase_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        upd_irq, upd_dma, trig_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tbase_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_irq(upd_irq), .upd_dma(upd_dma), .trig_out(trig_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; the write lands on the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        bus_wr = 1'b0;
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 ien", v, 0);
        rd(2, v); chk("R1 stat", v, 0);
        rd(4, v); chk("R1 count", v, 0);
        rd(5, v); chk("R1 presc", v, 0);
        rd(6, v); chk("R1 reload", v, 32'hFFFF);
        chk("R1 outs", {upd_irq, upd_dma, trig_out}, 0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        do_reset();
        wr(6, 5);          // R4 immediate limit with buffering off
        wr(1, 3);
        wr(0, 32'hA1);     // run, mirror, trigger = update pulse
        cyc(3); rd(4, v); chk("R2 count step", v, 2);
        cyc(3); rd(4, v); chk("R2 count at limit", v, 5);
        rd(2, v); chk("R2 no flag yet", v, 0);
        cyc(1); rd(4, v); chk("R2 R12 wrap with mirror", v, 32'h8000_0000);
        rd(2, v); chk("R2 flag on wrap", v, 1);
        chk("R8 irq", upd_irq, 1);
        chk("R9 dma pulse", upd_dma, 1);
        chk("R13 update trigger", trig_out, 1);
        cyc(1); chk("R9 dma one cycle", upd_dma, 0);
        chk("R13 update trigger ends", trig_out, 0);
        wr(2, 1); rd(2, v); chk("R8 write one keeps", v, 1);
        wr(2, 0); rd(2, v); chk("R8 write zero clears", v, 0);
        chk("R8 irq cleared", upd_irq, 0);
        rd(4, v); chk("R12 mirror follows", v[31], 0);
    endtask

    task automatic t_zero_limit();
        logic [31:0] v;
        do_reset();
        wr(6, 0);
        wr(0, 1);
        cyc(5); rd(4, v); chk("R2 zero limit blocks", v, 0);
        wr(4, 7); rd(4, v); chk("R14 count write", v, 7);
        wr(6, 9); rd(4, v); chk("R14 count kept", v, 7);
        cyc(2); rd(4, v); chk("R2 resumes", v, 9);
        cyc(1); rd(4, v); chk("R2 wrap after write", v, 0);
        rd(2, v); chk("R2 flag after write", v, 1);
        rd(4, v); chk("R12 mirror off", v[31], 0);
    endtask

    task automatic t_presc();
        logic [31:0] v;
        do_reset();
        wr(5, 2);
        wr(6, 100);
        wr(0, 1);
        cyc(4); rd(4, v); chk("R3 ratio not yet active", v, 3);
        wr(3, 1); rd(4, v); chk("R5 forced clears count", v, 0);
        rd(2, v); chk("R5 forced sets flag", v, 1);
        rd(3, v); chk("R5 event reads zero", v, 0);
        cyc(2); rd(4, v); chk("R3 divide by three hold", v, 0);
        cyc(1); rd(4, v); chk("R3 divide by three step", v, 1);
        cyc(3); rd(4, v); chk("R3 divide by three next", v, 2);
    endtask

    task automatic t_buffered();
        logic [31:0] v;
        do_reset();
        wr(0, 32'h10);
        wr(6, 3);
        wr(3, 1);
        wr(2, 0);
        wr(0, 32'h11);
        wr(6, 10);
        cyc(3); rd(4, v); chk("R4 old limit reached", v, 3);
        cyc(1); rd(4, v); chk("R4 old limit wraps", v, 0);
        rd(2, v); chk("R4 flag at wrap", v, 1);
        cyc(10); rd(4, v); chk("R4 new limit reached", v, 10);
        cyc(1); rd(4, v); chk("R4 new limit wraps", v, 0);
    endtask

    task automatic t_block();
        logic [31:0] v;
        do_reset();
        wr(0, 32'h02);
        wr(5, 3);
        wr(6, 4);
        wr(0, 32'h03);
        cyc(5); rd(4, v); chk("R6 count at limit", v, 4);
        cyc(1); rd(4, v); chk("R6 still wraps", v, 0);
        rd(2, v); chk("R6 no flag on wrap", v, 0);
        cyc(1);
        wr(3, 1); rd(4, v); chk("R6 forced restart", v, 0);
        rd(2, v); chk("R6 no flag on forced", v, 0);
        cyc(1); rd(4, v); chk("R6 ratio unchanged", v, 1);
        cyc(1); rd(4, v); chk("R6 ratio unchanged next", v, 2);
    endtask

    task automatic t_qual();
        logic [31:0] v;
        do_reset();
        wr(0, 32'h04);
        wr(5, 1);
        wr(6, 3);
        wr(3, 1);
        chk("R13 forced pulse trigger", trig_out, 1);
        rd(2, v); chk("R7 forced no flag", v, 0);
        cyc(1); chk("R13 forced pulse ends", trig_out, 0);
        wr(0, 32'h05);
        cyc(3); rd(4, v); chk("R7 ratio loaded", v, 1);
        cyc(2); rd(4, v); chk("R7 ratio loaded next", v, 2);
        cyc(4); rd(4, v); chk("R7 overflow wrap", v, 0);
        rd(2, v); chk("R7 overflow flags", v, 1);
    endtask

    task automatic t_one_shot();
        logic [31:0] v;
        do_reset();
        wr(6, 2);
        wr(0, 32'h09);
        cyc(3); rd(4, v); chk("R10 count at limit", v, 2);
        cyc(1); rd(4, v); chk("R10 wrap", v, 0);
        rd(0, v); chk("R10 run cleared", v[0], 0);
        cyc(3); rd(4, v); chk("R10 stays stopped", v, 0);
    endtask

    task automatic t_enable_lag();
        do_reset();
        wr(0, 32'h41);
        chk("R11 enable not yet", trig_out, 0);
        cyc(1); chk("R11 enable after one", trig_out, 1);
        wr(0, 32'h40);
        chk("R11 enable still on", trig_out, 1);
        cyc(1); chk("R11 enable off", trig_out, 0);
        wr(0, 32'h1C1);
        cyc(2); chk("R13 unused select gives zero", trig_out, 0);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_wrap();
        t_zero_limit();
        t_presc();
        t_buffered();
        t_block();
        t_qual();
        t_one_shot();
        t_enable_lag();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule